// File: doc/BRIEF.md
# Flash Command and Readback Unit

This block is the command front end of an embedded flash controller. Software writes a 32-bit command word that carries a protection keyword, an operation code and a 16-bit argument. The unit can return the non-volatile configuration bits, return read-only factory trim bits, change single configuration bits, erase the array and switch a unique-identifier view over the bottom of the flash read window. Results leave through one result register that yields 32 bits per read.

The flash array is modelled by a small register array with a computed reset image. Programming and erase time is modelled by a parameterised busy delay. Configuration bit 0 is the security bit. While it is set, the debug and fast-programming access enables are low. Only an erase that completes while the erase pin is high clears it.

The register bus has four selects: 0 is the command register (write), 1 is status (read), 2 is result (read) and 3 is mode (read/write, bit 0 is the ready-interrupt enable). Read data is combinational in the cycle of the read. Side effects take place at the clock edge that ends the read. The operation codes are: 0x01 set configuration bit, 0x02 clear configuration bit, 0x03 get configuration bits, 0x04 get trim bits, 0x05 enter identifier mode, 0x06 leave identifier mode, 0x07 erase all.

Top module: `flash_cmd_unit`

## Requirements
- R1: A command write whose bits 31:24 differ from 0x5A sets the error flag and is not executed: ready stays high and no configuration bit changes.
- R2: A status read returns ready in bit 0 and the error flag in bit 1. The edge that ends the read clears the error flag. After reset, status reads 0x1.
- R3: Command 0x03 ignores bits 23:8. Successive result reads after it return configuration bits 31:0, then bits 39:32 in the low byte of the next word. Every get command restarts at the first word.
- R4: Once all words of the selected set have been read, further result reads return 0. A result read with no get command since reset returns 0.
- R5: Command 0x04 returns the trim set. Word 0 holds the fixed value 7'b1000000 in bits 6:0 and the TRIM_MID parameter in bits 28:22. Word 1 holds TRIM_HIGH in bits 6:0. All other bits are zero.
- R6: No command changes the trim bits. The trim words read the same before and after set, clear and erase commands.
- R7: Commands 0x01 and 0x02 take bits 23:8 as a bit index. Ready is low for BUSY_CYCLES cycles and the bit changes when ready rises again. An index of 40 or more has no effect, and clearing bit 0 has no effect.
- R8: Array reads are granted and return stored data while set, clear and get commands are in progress. The reset image of array word i is i*0x01010101.
- R9: Command 0x05 makes ready fall at the next edge. While the mode is active, array word addresses 0 to 3 return UID_SEED ^ (i*0x9E3779B9), and higher addresses return the array.
- R10: Command 0x06 in identifier mode makes ready rise at the next edge. If the interrupt enable is set, irq is high for exactly that one cycle.
- R11: While configuration bit 0 is set, dbg_allow and fpp_allow are low. Otherwise both are high.
- R12: Command 0x07 holds ready low and arr_grant low for BUSY_CYCLES cycles. Array reads return 0 during that time. On completion every array word becomes 0xFFFFFFFF, and bit 0 is cleared only if erase_pin is high at that edge.
- R13: A command with a good keyword written while ready is low is dropped, except 0x06 in identifier mode. Unknown codes do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (0 when not reading) |
| arr_rd_en | input | 1 | Array read enable |
| arr_addr | input | ARR_AW | Array word address |
| arr_rdata | output | 32 | Array read data |
| arr_grant | output | 1 | Array read path available |
| erase_pin | input | 1 | Erase pin level |
| dbg_allow | output | 1 | Debug access permitted |
| fpp_allow | output | 1 | Fast-programming access permitted |
| irq | output | 1 | Ready interrupt pulse |

## Verification
The assertions assume the following about the inputs:
- At most one register access is made per cycle, and a read and a write never share a cycle.
- erase_pin is a settled level at the edge that completes an erase.
- BUSY_CYCLES is at least one.

The stimulus changes every input only at the falling clock edge. It issues one access per task call and holds erase_pin steady across each erase. It deliberately writes into busy windows and into the identifier mode, so that the dropping rules are exercised.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  localparam logic [7:0] CMD_KEY      = 8'h5A;
  localparam int         ARG_W        = 16;
  localparam logic [7:0] OP_SET_CFG   = 8'h01;
  localparam logic [7:0] OP_CLR_CFG   = 8'h02;
  localparam logic [7:0] OP_GET_CFG   = 8'h03;
  localparam logic [7:0] OP_GET_CAL   = 8'h04;
  localparam logic [7:0] OP_UID_START = 8'h05;
  localparam logic [7:0] OP_UID_STOP  = 8'h06;
  localparam logic [7:0] OP_ERASE_ALL = 8'h07;

  localparam logic [1:0] SEL_CMD    = 2'd0;
  localparam logic [1:0] SEL_STATUS = 2'd1;
  localparam logic [1:0] SEL_RESULT = 2'd2;
  localparam logic [1:0] SEL_MODE   = 2'd3;

  typedef enum logic [1:0] {RES_NONE, RES_CFG, RES_CAL} res_sel_e;
endpackage

// File: rtl/fcu_cmd_ctrl.sv
module fcu_cmd_ctrl
  import fcu_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_word,
  input  logic             stat_rd,
  input  logic             mode_wr,
  input  logic             mode_ien,
  output logic             ready,
  output logic             err,
  output logic             ien,
  output logic             irq,
  output logic             uid_mode,
  output logic             erase_busy,
  output logic             get_cfg_go,
  output logic             get_cal_go,
  output logic             set_go,
  output logic             clr_go,
  output logic             erase_go,
  output logic [ARG_W-1:0] op_arg
);
  localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;

  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [7:0]       op_q, op_n;
  logic [ARG_W-1:0] arg_q, arg_n;
  logic             uid_q, uid_n;
  logic             err_q, err_n;
  logic             ien_q, ien_n;
  logic             rdy_prev_q;

  logic             key_ok;
  logic [7:0]       code;
  logic [ARG_W-1:0] cmd_arg;
  logic             done;

  assign key_ok  = (cmd_word[31:24] == CMD_KEY);
  assign code    = cmd_word[7:0];
  assign cmd_arg = cmd_word[23:8];
  assign done    = busy_q && (cnt_q == '0);
  assign ready   = !busy_q && !uid_q;

  always_comb begin
    busy_n     = busy_q;
    cnt_n      = cnt_q;
    op_n       = op_q;
    arg_n      = arg_q;
    uid_n      = uid_q;
    err_n      = err_q;
    ien_n      = ien_q;
    get_cfg_go = 1'b0;
    get_cal_go = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) busy_n = 1'b0;
      else             cnt_n  = cnt_q - 1'b1;
    end
    if (mode_wr) ien_n = mode_ien;
    if (stat_rd) err_n = 1'b0;
    if (cmd_wr) begin
      if (!key_ok) begin
        err_n = 1'b1;
      end else if (ready) begin
        case (code)
          OP_SET_CFG, OP_CLR_CFG, OP_ERASE_ALL: begin
            busy_n = 1'b1;
            cnt_n  = CNT_W'(BUSY_CYCLES - 1);
            op_n   = code;
            arg_n  = cmd_arg;
          end
          OP_GET_CFG:   get_cfg_go = 1'b1;
          OP_GET_CAL:   get_cal_go = 1'b1;
          OP_UID_START: uid_n      = 1'b1;
          default: ;
        endcase
      end else if (uid_q && code == OP_UID_STOP) begin
        uid_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      op_q       <= '0;
      arg_q      <= '0;
      uid_q      <= 1'b0;
      err_q      <= 1'b0;
      ien_q      <= 1'b0;
      rdy_prev_q <= 1'b1;
    end else begin
      busy_q     <= busy_n;
      cnt_q      <= cnt_n;
      op_q       <= op_n;
      arg_q      <= arg_n;
      uid_q      <= uid_n;
      err_q      <= err_n;
      ien_q      <= ien_n;
      rdy_prev_q <= ready;
    end
  end

  assign err        = err_q;
  assign ien        = ien_q;
  assign uid_mode   = uid_q;
  assign irq        = ien_q && ready && !rdy_prev_q;
  assign erase_busy = busy_q && (op_q == OP_ERASE_ALL);
  assign set_go     = done && (op_q == OP_SET_CFG);
  assign clr_go     = done && (op_q == OP_CLR_CFG);
  assign erase_go   = done && (op_q == OP_ERASE_ALL);
  assign op_arg     = arg_q;

  assert_bad_key_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !key_ok) |=> err_q);
  assert_bad_key_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !key_ok && ready) |=> ready);
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_stop_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (uid_q && cmd_wr && key_ok && code == OP_UID_STOP) |=> ready);
endmodule

// File: rtl/fcu_nvm_bits.sv
module fcu_nvm_bits
  import fcu_pkg::*;
#(
  parameter int              CFG_BITS  = 40,
  parameter logic [6:0]      TRIM_MID  = 7'h55,
  parameter logic [6:0]      TRIM_HIGH = 7'h2A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_go,
  input  logic             clr_go,
  input  logic             erase_go,
  input  logic             erase_pin,
  input  logic [ARG_W-1:0] bit_arg,
  input  logic             get_cfg_go,
  input  logic             get_cal_go,
  input  logic             res_rd,
  output logic [31:0]      res_data,
  output logic             sec_on
);
  localparam int CFG_WORDS = (CFG_BITS + 31) / 32;
  localparam int CAL_WORDS = 2;
  localparam int MAX_WORDS = (CFG_WORDS > CAL_WORDS) ? CFG_WORDS : CAL_WORDS;
  localparam int IDX_W     = $clog2(MAX_WORDS + 1);
  localparam logic [CAL_WORDS*32-1:0] CAL_VEC =
    {25'b0, TRIM_HIGH, 3'b0, TRIM_MID, 15'b0, 7'b1000000};

  logic [CFG_BITS-1:0]     cfg_q, cfg_n;
  res_sel_e                sel_q, sel_n;
  logic [IDX_W-1:0]        idx_q, idx_n;
  logic [CFG_WORDS*32-1:0] cfg_pad;
  int                      cur_words;

  always_comb begin
    cfg_pad = '0;
    cfg_pad[CFG_BITS-1:0] = cfg_q;
  end

  always_comb begin
    case (sel_q)
      RES_CFG: cur_words = CFG_WORDS;
      RES_CAL: cur_words = CAL_WORDS;
      default: cur_words = 0;
    endcase
  end

  always_comb begin
    cfg_n = cfg_q;
    sel_n = sel_q;
    idx_n = idx_q;
    for (int b = 0; b < CFG_BITS; b++) begin
      if (set_go && int'(bit_arg) == b) cfg_n[b] = 1'b1;
      if (clr_go && b != 0 && int'(bit_arg) == b) cfg_n[b] = 1'b0;
    end
    if (erase_go && erase_pin) cfg_n[0] = 1'b0;
    if (res_rd && int'(idx_q) < cur_words) idx_n = idx_q + 1'b1;
    if (get_cfg_go) begin
      sel_n = RES_CFG;
      idx_n = '0;
    end
    if (get_cal_go) begin
      sel_n = RES_CAL;
      idx_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sel_q <= RES_NONE;
      idx_q <= '0;
    end else begin
      cfg_q <= cfg_n;
      sel_q <= sel_n;
      idx_q <= idx_n;
    end
  end

  always_comb begin
    res_data = '0;
    if (sel_q == RES_CFG) begin
      for (int w = 0; w < CFG_WORDS; w++)
        if (int'(idx_q) == w) res_data = cfg_pad[w*32 +: 32];
    end else if (sel_q == RES_CAL) begin
      for (int w = 0; w < CAL_WORDS; w++)
        if (int'(idx_q) == w) res_data = CAL_VEC[w*32 +: 32];
    end
  end

  assign sec_on = cfg_q[0];

  assert_sec_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_q[0]) |-> $past(erase_go && erase_pin));
  assert_idx_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (get_cfg_go || get_cal_go) |=> (idx_q == '0));
endmodule

// File: rtl/fcu_array_port.sv
module fcu_array_port #(
  parameter int          ARR_WORDS = 16,
  parameter int          ARR_AW    = 4,
  parameter int          UID_WORDS = 4,
  parameter logic [31:0] UID_SEED  = 32'h3C5AE10F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_go,
  input  logic              erase_busy,
  input  logic              uid_mode,
  input  logic              rd_en,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              grant
);
  logic [31:0] mem_q [ARR_WORDS];
  logic [31:0] mem_n [ARR_WORDS];

  function automatic logic [31:0] uid_word(input int u);
    return UID_SEED ^ (32'(u) * 32'h9E3779B9);
  endfunction

  always_comb begin
    mem_n = mem_q;
    if (erase_go)
      for (int w = 0; w < ARR_WORDS; w++) mem_n[w] = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < ARR_WORDS; w++) mem_q[w] <= 32'(w) * 32'h01010101;
    end else begin
      mem_q <= mem_n;
    end
  end

  assign grant = !erase_busy;

  always_comb begin
    rd_data = '0;
    if (rd_en && grant) begin
      for (int w = 0; w < ARR_WORDS; w++)
        if (int'(rd_addr) == w) rd_data = mem_q[w];
      if (uid_mode)
        for (int u = 0; u < UID_WORDS; u++)
          if (int'(rd_addr) == u) rd_data = uid_word(u);
    end
  end

  assert_erase_fill_R12: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (mem_q[0] == 32'hFFFFFFFF));
endmodule

// File: rtl/flash_cmd_unit.sv
module flash_cmd_unit
  import fcu_pkg::*;
#(
  parameter int          BUSY_CYCLES = 4,
  parameter int          CFG_BITS    = 40,
  parameter int          ARR_WORDS   = 16,
  parameter int          ARR_AW      = 4,
  parameter logic [6:0]  TRIM_MID    = 7'h55,
  parameter logic [6:0]  TRIM_HIGH   = 7'h2A,
  parameter logic [31:0] UID_SEED    = 32'h3C5AE10F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_sel,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              arr_rd_en,
  input  logic [ARR_AW-1:0] arr_addr,
  output logic [31:0]       arr_rdata,
  output logic              arr_grant,
  input  logic              erase_pin,
  output logic              dbg_allow,
  output logic              fpp_allow,
  output logic              irq
);
  localparam int UID_WORDS = 4;

  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic             cmd_wr, stat_rd, res_rd, mode_wr;
  logic             ready, err, ien, uid_mode, erase_busy;
  logic             get_cfg_go, get_cal_go, set_go, clr_go, erase_go;
  logic [ARG_W-1:0] op_arg;
  logic [31:0]      res_data;
  logic             sec_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign cmd_wr  = bus_wr && (bus_sel == SEL_CMD);
  assign mode_wr = bus_wr && (bus_sel == SEL_MODE);
  assign stat_rd = bus_rd && (bus_sel == SEL_STATUS);
  assign res_rd  = bus_rd && (bus_sel == SEL_RESULT);

  fcu_cmd_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) ctrl_i (
    .clk(clk), .rst_n(rst_n_i),
    .cmd_wr(cmd_wr), .cmd_word(bus_wdata), .stat_rd(stat_rd),
    .mode_wr(mode_wr), .mode_ien(bus_wdata[0]),
    .ready(ready), .err(err), .ien(ien), .irq(irq),
    .uid_mode(uid_mode), .erase_busy(erase_busy),
    .get_cfg_go(get_cfg_go), .get_cal_go(get_cal_go),
    .set_go(set_go), .clr_go(clr_go), .erase_go(erase_go),
    .op_arg(op_arg)
  );

  fcu_nvm_bits #(.CFG_BITS(CFG_BITS), .TRIM_MID(TRIM_MID), .TRIM_HIGH(TRIM_HIGH)) nvm_i (
    .clk(clk), .rst_n(rst_n_i),
    .set_go(set_go), .clr_go(clr_go), .erase_go(erase_go),
    .erase_pin(erase_pin), .bit_arg(op_arg),
    .get_cfg_go(get_cfg_go), .get_cal_go(get_cal_go),
    .res_rd(res_rd), .res_data(res_data), .sec_on(sec_on)
  );

  fcu_array_port #(.ARR_WORDS(ARR_WORDS), .ARR_AW(ARR_AW),
                   .UID_WORDS(UID_WORDS), .UID_SEED(UID_SEED)) arr_i (
    .clk(clk), .rst_n(rst_n_i),
    .erase_go(erase_go), .erase_busy(erase_busy), .uid_mode(uid_mode),
    .rd_en(arr_rd_en), .rd_addr(arr_addr), .rd_data(arr_rdata),
    .grant(arr_grant)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_sel)
        SEL_STATUS: bus_rdata = {30'b0, err, ready};
        SEL_RESULT: bus_rdata = res_data;
        SEL_MODE:   bus_rdata = {31'b0, ien};
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign dbg_allow = !sec_on;
  assign fpp_allow = !sec_on;

  assert_uid_enter_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(uid_mode) |-> $past(cmd_wr && bus_wdata[7:0] == OP_UID_START));
endmodule

// File: tb/flash_cmd_unit_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_unit_tb_top;
  localparam int          BUSY  = 4;
  localparam logic [6:0]  TMID  = 7'h55;
  localparam logic [6:0]  THIGH = 7'h2A;
  localparam logic [31:0] SEED  = 32'h3C5AE10F;

  logic        clk, rst_n;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_sel;
  logic [31:0] bus_wdata, bus_rdata;
  logic        arr_rd_en;
  logic [3:0]  arr_addr;
  logic [31:0] arr_rdata;
  logic        arr_grant, erase_pin, dbg_allow, fpp_allow, irq;

  flash_cmd_unit #(.BUSY_CYCLES(BUSY), .TRIM_MID(TMID), .TRIM_HIGH(THIGH),
                   .UID_SEED(SEED)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .arr_rd_en(arr_rd_en), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
    .arr_grant(arr_grant), .erase_pin(erase_pin), .dbg_allow(dbg_allow),
    .fpp_allow(fpp_allow), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit run    = 0;
  bit done   = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // behavioural reference model
  bit          m_busy, m_uid, m_ien, m_rprev, m_pre;
  int          m_cnt, m_op, m_arg, m_code;
  logic [39:0] m_cfg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_uid = 0; m_ien = 0; m_rprev = 1;
      m_cnt = 0; m_op = 0; m_arg = 0; m_cfg = '0;
    end else begin
      m_pre = !m_busy && !m_uid;
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy = 0;
          if (m_op == 1 && m_arg < 40) m_cfg[m_arg] = 1'b1;
          if (m_op == 2 && m_arg < 40 && m_arg != 0) m_cfg[m_arg] = 1'b0;
          if (m_op == 7 && erase_pin) m_cfg[0] = 1'b0;
        end else m_cnt--;
      end
      if (bus_wr && bus_sel == 2'd3) m_ien = bus_wdata[0];
      if (bus_wr && bus_sel == 2'd0 && bus_wdata[31:24] == 8'h5A) begin
        m_code = bus_wdata[7:0];
        if (m_pre) begin
          if (m_code == 1 || m_code == 2 || m_code == 7) begin
            m_busy = 1; m_cnt = BUSY - 1; m_op = m_code; m_arg = bus_wdata[23:8];
          end else if (m_code == 5) m_uid = 1;
        end else if (m_uid && m_code == 6) m_uid = 0;
      end
      m_rprev = m_pre;
    end
  end

  always @(negedge clk) begin
    if (run && !done) begin
      chk("R10 irq per clock", {31'b0, irq}, {31'b0, m_ien && !m_busy && !m_uid && !m_rprev});
      chk("R11 dbg per clock", {31'b0, dbg_allow}, {31'b0, !m_cfg[0]});
      chk("R11 fpp per clock", {31'b0, fpp_allow}, {31'b0, !m_cfg[0]});
      chk("R12 grant per clock", {31'b0, arr_grant}, {31'b0, !(m_busy && m_op == 7)});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] code, input logic [15:0] arg);
    wr(2'd0, {8'h5A, arg, code});
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_sel = sel; bus_rd = 1'b1;
    #1 chk(req, bus_rdata, exp);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic ard(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    arr_addr = a; arr_rd_en = 1'b1;
    #1 chk(req, arr_rdata, exp);
    arr_rd_en = 1'b0;
  endtask

  function automatic logic [31:0] uidw(input int u);
    return SEED ^ (32'(u) * 32'h9E3779B9);
  endfunction

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_sel = 0; bus_wdata = 0;
    arr_rd_en = 0; arr_addr = 0; erase_pin = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    run = 1;

    rd(2'd1, 32'h1, "R2 reset status");
    rd(2'd2, 32'h0, "R4 result before any get");

    cmd(8'h01, 16'd5);
    rd(2'd1, 32'h0, "R7 ready low while setting");
    ard(4'd2, 32'h02020202, "R8 array read during set");
    idle(BUSY + 1);
    cmd(8'h01, 16'd37); idle(BUSY + 1);
    cmd(8'h01, 16'd50); idle(BUSY + 1);

    cmd(8'h03, 16'hBEEF);
    ard(4'd3, 32'h03030303, "R8 array read during get");
    rd(2'd2, 32'h20, "R3 cfg word 0");
    rd(2'd2, 32'h20, "R3 cfg word 1 (bit 37), R7 index 50 ignored");
    rd(2'd2, 32'h0, "R4 past end");
    rd(2'd2, 32'h0, "R4 past end again");
    cmd(8'h03, 16'h0);
    rd(2'd2, 32'h20, "R3 index restarts");

    cmd(8'h04, 16'h0);
    rd(2'd2, 32'h40 | (32'(TMID) << 22), "R5 trim word 0");
    rd(2'd2, 32'(THIGH), "R5 trim word 1");
    rd(2'd2, 32'h0, "R4 trim past end");
    cmd(8'h01, 16'd6); idle(BUSY + 1);
    cmd(8'h04, 16'h0);
    rd(2'd2, 32'h40 | (32'(TMID) << 22), "R6 trim unchanged");

    wr(2'd0, {8'hA5, 16'd9, 8'h01});
    rd(2'd1, 32'h3, "R1 error set, still ready");
    rd(2'd1, 32'h1, "R2 error cleared by read");
    idle(BUSY + 1);
    cmd(8'h03, 16'h0);
    rd(2'd2, 32'h60, "R1 bad-key command not executed");

    cmd(8'h01, 16'd3);
    cmd(8'h01, 16'd4);
    idle(BUSY + 1);
    cmd(8'h03, 16'h0);
    rd(2'd2, 32'h68, "R13 command during busy dropped");

    chk("R11 open before security", {31'b0, dbg_allow}, 32'h1);
    cmd(8'h01, 16'd0); idle(BUSY + 1);
    chk("R11 dbg denied", {31'b0, dbg_allow}, 32'h0);
    chk("R11 fpp denied", {31'b0, fpp_allow}, 32'h0);
    cmd(8'h02, 16'd0); idle(BUSY + 1);
    chk("R7 clear of bit 0 ignored", {31'b0, dbg_allow}, 32'h0);
    cmd(8'h02, 16'd5); idle(BUSY + 1);
    cmd(8'h03, 16'h0);
    rd(2'd2, 32'h49, "R7 clear bit 5");

    erase_pin = 1'b0;
    cmd(8'h07, 16'h0);
    chk("R12 grant low during erase", {31'b0, arr_grant}, 32'h0);
    ard(4'd1, 32'h0, "R12 read blocked during erase");
    idle(BUSY + 1);
    chk("R12 pin low keeps security", {31'b0, dbg_allow}, 32'h0);
    ard(4'd1, 32'hFFFFFFFF, "R12 array erased");
    erase_pin = 1'b1;
    cmd(8'h07, 16'h0); idle(BUSY + 1);
    chk("R12 pin high clears security", {31'b0, dbg_allow}, 32'h1);
    erase_pin = 1'b0;

    wr(2'd3, 32'h1);
    rd(2'd3, 32'h1, "R10 interrupt enable readback");
    cmd(8'h05, 16'h0);
    rd(2'd1, 32'h0, "R9 ready low in identifier mode");
    ard(4'd0, uidw(0), "R9 identifier word 0");
    ard(4'd3, uidw(3), "R9 identifier word 3");
    ard(4'd4, 32'hFFFFFFFF, "R9 word 4 from array");
    cmd(8'h03, 16'h0);
    rd(2'd2, 32'h20, "R13 get dropped in identifier mode");
    cmd(8'h06, 16'h0);
    chk("R10 irq on ready rise", {31'b0, irq}, 32'h1);
    rd(2'd1, 32'h1, "R10 ready back");
    chk("R10 irq single cycle", {31'b0, irq}, 32'h0);
    ard(4'd0, 32'hFFFFFFFF, "R9 identifier view gone");

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule